// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block collects up to fifteen asynchronous interrupt request lines and presents one request to a processor. It is built from two identical eight-line priority units. The secondary unit's request output feeds line 2 of the primary unit, so the eight secondary lines share one slot in the primary's priority order. Each unit latches rising edges of its synchronized inputs into a request register. It gates them with a mask register and tracks handlers in progress in an in-service register.

The processor writes each unit's mask through a mask port and sends commands through a command port, using a byte-wide write bus. When the processor answers `int_o` with a one-cycle acknowledge, the controller places the winning line's vector number on `vec_o` in that same cycle. It moves the line from requested to in service. Lines of equal or lower priority stay blocked until the handler writes the end-of-interrupt code to the unit that owns the in-service bit. A secondary line has to be released in both units.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, all request, in-service and mask bits are 0, `int_o` is 0 and `vec_o` is 00h.
- R2: A rising edge on `irq_i[n]` (n ≠ 2) sets request bit n on the third rising clock edge after the input change. A level held high does not request again after service. `irq_i[2]` has no effect.
- R3: Bit n of the byte written to address 21h masks primary line n when 1. Bit k of the byte written to address A1h masks secondary line 8+k when 1. Primary mask bit 2 blocks all secondary lines. A masked request stays latched and is served once unmasked.
- R4: Among unmasked, unblocked pending lines the winner follows the fixed order 0, 1, 8, 9, …, 15, 3, 4, 5, 6, 7.
- R5: During an acknowledge cycle with `int_o` high, `vec_o` equals 08h+n for primary line n and 70h+k for secondary line 8+k. At all other times `vec_o` is 00h.
- R6: On an accepted acknowledge, the winner's request bit is cleared and its in-service bit is set at the same clock edge. For a secondary line, both the secondary bit and primary in-service bit 2 are set.
- R7: `int_o` is high only if a candidate exists for which no in-service bit of equal or higher priority is set in its unit, and, for secondary lines, also in primary bit 2. A higher-priority line therefore nests over a handler in progress.
- R8: Writing 20h to a unit's command port (20h primary, A0h secondary) clears that unit's highest-priority set in-service bit. Other data written to a command port leaves the in-service bits unchanged.
- R9: A further rising edge on a line whose request bit is still set merges into it, giving a single service.
- R10: An acknowledge while `int_o` is low changes no state and gives `vec_o` = 00h.
- R11: Writes to addresses other than 20h, 21h, A0h and A1h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Asynchronous request lines; bit 2 unused |
| wr_i | input | 1 | Write strobe for the port bus |
| addr_i | input | 8 | Port address |
| wdata_i | input | 8 | Write data |
| inta_i | input | 1 | One-cycle acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number during an accepted acknowledge |

## Verification
The assertions assume that `inta_i` is a single-cycle pulse and that writes are single-cycle strobes. They also assume that each request pulse stays high and then low for at least two clocks, so the synchronizer sees every edge. The stimulus raises each line for two clocks, holds acknowledges and writes for exactly one clock, and waits four clocks after a pulse before acting. It also sends acknowledges while `int_o` is low, on purpose, to cover R10. A behavioural model in the bench walks the flat priority list every cycle and compares `int_o` and `vec_o`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int          UNIT_LINES  = 8;
  parameter int          DATA_W      = 8;
  parameter int          CASC_SLOT   = 2;
  parameter logic [7:0]  PRI_VEC     = 8'h08;
  parameter logic [7:0]  SEC_VEC     = 8'h70;
  parameter logic [7:0]  EOI_CODE    = 8'h20;
  parameter logic [7:0]  PRI_CMD_ADR = 8'h20;
  parameter logic [7:0]  PRI_MSK_ADR = 8'h21;
  parameter logic [7:0]  SEC_CMD_ADR = 8'hA0;
  parameter logic [7:0]  SEC_MSK_ADR = 8'hA1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit #(
  parameter int         LINES     = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] VEC_BASE  = 8'h08,
  parameter logic [7:0] EOI_CODE  = 8'h20,
  parameter bit         CASC_EN   = 1'b0,
  parameter int         CASC_LINE = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LINES-1:0]         req_i,
  input  logic                     casc_i,
  input  logic                     mask_we_i,
  input  logic                     cmd_we_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     ack_i,
  output logic                     int_o,
  output logic [$clog2(LINES)-1:0] win_o,
  output logic [LINES-1:0]         isr_o,
  output logic [7:0]               vec_o
);
  localparam int IW = $clog2(LINES);

  logic [LINES-1:0] irr_q, irr_d;
  logic [LINES-1:0] isr_q, isr_d;
  logic [LINES-1:0] imr_q, imr_d;
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] casc_sel, rise, irr_view, pend;
  logic [LINES-1:0] win_oh, top_oh;
  logic [IW-1:0]    win_idx, top_idx;
  logic             any_pend, any_isr, ack_take, eoi;

  // variant: cascade slot replaces one latched line by a live level
  generate
    if (CASC_EN) begin : g_casc
      assign casc_sel = LINES'(1) << CASC_LINE;
    end else begin : g_plain
      assign casc_sel = '0;
    end
  endgenerate

  function automatic logic [IW-1:0] first_set(input logic [LINES-1:0] v);
    logic [IW-1:0] idx;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) idx = IW'(i);
    end
    return idx;
  endfunction

  always_comb begin
    rise     = req_i & ~prev_q & ~casc_sel;
    irr_view = (irr_q & ~casc_sel) | (casc_i ? casc_sel : '0);
    pend     = irr_view & ~imr_q;
    any_pend = |pend;
    win_idx  = first_set(pend);
    win_oh   = any_pend ? (LINES'(1) << win_idx) : '0;
    any_isr  = |isr_q;
    top_idx  = first_set(isr_q);
    top_oh   = any_isr ? (LINES'(1) << top_idx) : '0;
    int_o    = any_pend && (!any_isr || (win_idx < top_idx));
    ack_take = ack_i && int_o;
    eoi      = cmd_we_i && (wdata_i == DATA_W'(EOI_CODE));
  end

  // next-state
  always_comb begin
    irr_d = (irr_q & ~(ack_take ? win_oh : '0)) | rise;
    isr_d = (isr_q & ~(eoi ? top_oh : '0)) | (ack_take ? win_oh : '0);
    imr_d = mask_we_i ? wdata_i[LINES-1:0] : imr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      prev_q <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      imr_q  <= imr_d;
      prev_q <= req_i;
    end
  end

  assign win_o = win_idx;
  assign isr_o = isr_q;
  assign vec_o = VEC_BASE + 8'(win_idx);

  p_ack_clears_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_take && ((rise & win_oh) == '0)) |=> ((irr_q & $past(win_oh)) == '0));

  p_ack_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take |=> ((isr_q & $past(win_oh)) != '0));

  p_eoi_drops_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !ack_take && any_isr) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  p_other_cmd_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoi && !ack_take) |=> ((isr_q & ~$past(isr_q)) == '0 && $countones(isr_q) == $countones($past(isr_q))));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irq_pkg::*;
#(
  parameter int LINES = UNIT_LINES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*LINES-1:0] irq_i,
  input  logic               wr_i,
  input  logic [7:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               inta_i,
  output logic               int_o,
  output logic [7:0]         vec_o
);
  localparam int IW = $clog2(LINES);

  logic [2*LINES-1:0] irq_s;
  logic               m_int, s_int, m_ack, s_ack;
  logic [IW-1:0]      m_win, s_win;
  logic [LINES-1:0]   m_isr, s_isr;
  logic [7:0]         m_vec, s_vec;
  logic               m_msk_we, m_cmd_we, s_msk_we, s_cmd_we;

  irq_sync #(.W(2*LINES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(irq_i), .sync_o(irq_s)
  );

  always_comb begin
    m_msk_we = wr_i && (addr_i == PRI_MSK_ADR);
    m_cmd_we = wr_i && (addr_i == PRI_CMD_ADR);
    s_msk_we = wr_i && (addr_i == SEC_MSK_ADR);
    s_cmd_we = wr_i && (addr_i == SEC_CMD_ADR);
    m_ack    = inta_i && m_int;
    s_ack    = m_ack && (m_win == IW'(CASC_SLOT));
    vec_o    = m_ack ? (s_ack ? s_vec : m_vec) : 8'h00;
  end

  irq_prio_unit #(
    .LINES(LINES), .DATA_W(DATA_W), .VEC_BASE(PRI_VEC), .EOI_CODE(EOI_CODE),
    .CASC_EN(1'b1), .CASC_LINE(CASC_SLOT)
  ) u_primary (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(irq_s[LINES-1:0]), .casc_i(s_int),
    .mask_we_i(m_msk_we), .cmd_we_i(m_cmd_we), .wdata_i(wdata_i), .ack_i(inta_i),
    .int_o(m_int), .win_o(m_win), .isr_o(m_isr), .vec_o(m_vec)
  );

  irq_prio_unit #(
    .LINES(LINES), .DATA_W(DATA_W), .VEC_BASE(SEC_VEC), .EOI_CODE(EOI_CODE),
    .CASC_EN(1'b0), .CASC_LINE(CASC_SLOT)
  ) u_secondary (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(irq_s[2*LINES-1:LINES]), .casc_i(1'b0),
    .mask_we_i(s_msk_we), .cmd_we_i(s_cmd_we), .wdata_i(wdata_i), .ack_i(s_ack),
    .int_o(s_int), .win_o(s_win), .isr_o(s_isr), .vec_o(s_vec)
  );

  assign int_o = m_int;

  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_ack |-> ((vec_o >= PRI_VEC && vec_o < PRI_VEC + 8'(LINES)) ||
               (vec_o >= SEC_VEC && vec_o < SEC_VEC + 8'(LINES))));

  p_sec_marks_pri_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ack |=> (m_isr[CASC_SLOT] && s_isr != '0));

  p_no_vec_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_ack |-> (vec_o == 8'h00));
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        inta = 1'b0;
  logic        int_w;
  logic [7:0]  vec_w;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cascade_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .inta_i(inta), .int_o(int_w), .vec_o(vec_w)
  );

  // behavioural reference
  bit [15:0] s1, s2, pv, req;
  bit [7:0]  pis, sis, pmk, smk;

  function automatic int order_at(int k);
    if (k < 2) return k;
    if (k < 10) return k + 6;
    return k - 7;
  endfunction

  function automatic bit blocked(bit [7:0] isr, int idx);
    for (int j = 0; j <= idx; j++) if (isr[j]) return 1;
    return 0;
  endfunction

  function automatic void model_eval(output bit iv, output int wl);
    iv = 0; wl = -1;
    for (int k = 0; k < 15; k++) begin
      int L, mi;
      L = order_at(k);
      mi = (L < 8) ? L : 2;
      if (!req[L] || pmk[mi]) continue;
      if (L >= 8) begin
        if (smk[L-8] || blocked(sis, L - 8)) continue;
      end
      if (blocked(pis, mi)) return;
      iv = 1; wl = L;
      return;
    end
  endfunction

  function automatic int vec_of(int L);
    return (L < 8) ? 8 + L : 'h70 + L - 8;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      s1 = '0; s2 = '0; pv = '0; req = '0; pis = '0; sis = '0; pmk = '0; smk = '0;
    end else if (!done) begin
      bit iv; int wl; int ev;
      bit [15:0] rise;
      model_eval(iv, wl);
      ev = (inta && iv) ? vec_of(wl) : 0;
      check(int_w == iv, "R4 R7 model int_o", int_w, iv);
      check(vec_w == ev, "R5 R10 model vec_o", vec_w, ev);
      rise = s2 & ~pv & ~16'h0004;
      if (inta && iv) req[wl] = 0;
      req |= rise;
      if (wr && addr == 8'h20 && wdata == 8'h20)
        for (int j = 0; j < 8; j++) if (pis[j]) begin pis[j] = 0; break; end
      if (wr && addr == 8'hA0 && wdata == 8'h20)
        for (int j = 0; j < 8; j++) if (sis[j]) begin sis[j] = 0; break; end
      if (inta && iv) begin
        if (wl < 8) pis[wl] = 1;
        else begin pis[2] = 1; sis[wl-8] = 1; end
      end
      if (wr && addr == 8'h21) pmk = wdata;
      if (wr && addr == 8'hA1) smk = wdata;
      pv = s2; s2 = s1; s1 = irq;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(bit [15:0] lines);
    irq = lines; step(2);
    irq = '0;    step(4);
  endtask

  task automatic write(bit [7:0] a, bit [7:0] d);
    wr = 1; addr = a; wdata = d; step(1);
    wr = 0; step(1);
  endtask

  task automatic ack(int exp, string tag);
    inta = 1; #3;
    check(vec_w == exp, tag, vec_w, exp);
    step(1);
    inta = 0; step(1);
  endtask

  task automatic expect_int(bit exp, string tag);
    #2;
    check(int_w == exp, tag, int_w, exp);
  endtask

  initial begin
    step(3);
    check(int_w == 0 && vec_w == 0, "R1 in reset", {int_w, vec_w}, 0);
    rst_n = 1; step(2);
    check(int_w == 0 && vec_w == 0, "R1 after reset", {int_w, vec_w}, 0);

    // R2 latch latency and single service
    irq = 16'h0010; step(2);
    expect_int(0, "R2 before third edge");
    step(1);
    expect_int(1, "R2 latched");
    step(3);
    ack('h0C, "R5 line 4 vector");
    expect_int(0, "R2 held level no re-request");
    irq = '0; step(2);
    write(8'h20, 8'h20);

    // R4 order 1, 9, 3
    pulse(16'h020A);
    ack('h09, "R4 line 1 first");
    expect_int(0, "R7 lower blocked");
    write(8'h20, 8'h20);
    expect_int(1, "R4 secondary pending");
    ack('h71, "R4 line 9 before 3");
    write(8'hA0, 8'h20);
    expect_int(0, "R8 primary slot still in service");
    write(8'h20, 8'h20);
    ack('h0B, "R4 line 3 last");
    write(8'h20, 8'h20);

    // R7 nesting
    pulse(16'h0040);
    ack('h0E, "R5 line 6");
    pulse(16'h0001);
    expect_int(1, "R7 higher nests");
    ack('h08, "R7 line 0 vector");
    write(8'h20, 8'h20);
    write(8'h20, 8'h20);

    // R3 masking
    write(8'h21, 8'h40);
    pulse(16'h0040);
    expect_int(0, "R3 line 6 masked");
    write(8'h21, 8'h00);
    expect_int(1, "R3 unmasked serves");
    ack('h0E, "R3 line 6 vector");
    write(8'h20, 8'h20);
    write(8'h21, 8'h04);
    pulse(16'h1000);
    expect_int(0, "R3 slot 2 masks secondary");
    write(8'h21, 8'h00);
    ack('h74, "R3 line 12 vector");
    write(8'hA0, 8'h20);
    write(8'h20, 8'h20);
    write(8'hA1, 8'h01);
    pulse(16'h0100);
    expect_int(0, "R3 secondary bit masks line 8");
    write(8'hA1, 8'h00);
    ack('h70, "R3 line 8 vector");
    write(8'hA0, 8'h20);
    write(8'h20, 8'h20);

    // R9 saturation
    pulse(16'h0020);
    pulse(16'h0020);
    ack('h0D, "R9 line 5 vector");
    expect_int(0, "R9 merged edge");
    // R8 other command data ignored
    pulse(16'h0080);
    expect_int(0, "R7 line 7 blocked by 5");
    write(8'h20, 8'h60);
    expect_int(0, "R8 non-eoi ignored");
    write(8'h20, 8'h20);
    expect_int(1, "R8 eoi releases");
    ack('h0F, "R8 line 7 vector");
    write(8'h20, 8'h20);

    // R10 idle acknowledge
    ack(0, "R10 idle ack vector");
    expect_int(0, "R10 no state change");

    // R11 stray address, line 2 ignored
    write(8'h22, 8'hFF);
    write(8'h60, 8'h20);
    pulse(16'h0008);
    expect_int(1, "R11 stray writes ignored");
    ack('h0B, "R11 line 3 vector");
    write(8'h20, 8'h20);
    pulse(16'h0004);
    expect_int(0, "R2 input 2 ignored");
    step(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule